// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of an Ethernet DMA engine. Frame bytes arrive one per beat on a valid/ready byte stream. Each beat carries a start-of-frame marker, an end-of-frame marker and a broadcast flag. The block places the bytes into 128-byte buffers that live in a word-wide memory. It finds those buffers by walking a ring of two-word descriptors held in the same memory.

Each descriptor has an address word and a status word. The address word gives the buffer location in bits 31:2. Its bit 0 is the ownership flag and its bit 1 ends the ring. For every buffer, the block reads the address word and rejects the buffer if it is already owned. It then writes the frame bytes and writes the status word. Last, it rewrites the address word with the ownership flag set. Software returns a buffer by clearing that flag.

A frame longer than one buffer is spread over consecutive descriptors, and the chain may wrap back to the ring base in the middle of a frame. The ring base is loaded while the receiver is disabled. Loading it restarts the walk at descriptor 0.

Stream rules:
- A beat transfers when `s_valid` and `s_ready` are both high at a clock edge.
- While idle and enabled, beats without the start marker are accepted and discarded.
- A start-marked beat is held, with `s_ready` low in that same cycle, until its first descriptor has been fetched.
- `s_ready` is low during descriptor fetch, descriptor check, status write and ownership write.
- The source may leave gaps between beats at any time.

Top module: `rxr_ring_writer`

## Requirements
- R1: While idle with `rx_enable` high, a beat without `s_first` is consumed with no memory access. A beat with `s_first` is not consumed until a descriptor has been fetched. While idle with `rx_enable` low, `s_ready` stays low and no frame starts.
- R2: Before the first byte of every buffer, the block issues one read of the descriptor address word at `base + 8*index`. Each byte is then written to `buffer + offset`, in arrival order. The write uses byte strobe `mem_be = 1 << addr[1:0]` and carries the byte replicated on all four lanes.
- R3: After 128 bytes with no end marker, the buffer is closed, the next descriptor is fetched and the frame continues into it.
- R4: The status word is written at `base + 8*index + 4` with all four strobes. Its fields are:
  - bit 14: set on the first buffer of a frame.
  - bit 15: set on the last buffer of a frame.
  - bits 11:0: the total frame length, on the last buffer only; zero on other buffers.
  - bit 31: the broadcast flag sampled with the start beat, on the last buffer only.
  - all other bits: zero.
- R5: In the cycle after the status write, the address word is rewritten. The new value keeps the buffer address bits and bit 1, and has bit 0 set.
- R6: After a descriptor whose bit 1 is set, or after index `RING_DEPTH-1`, the next descriptor is index 0. This also applies in the middle of a frame.
- R7: If the fetched address word already has bit 0 set, `overrun_pulse` is high for exactly that one cycle and nothing is written. The rest of the frame, up to and including the `s_last` beat, is consumed and discarded. The index does not advance.
- R8: `base_load` takes `base_value` only while `rx_enable` is low and the block is idle, and it resets the index to 0. With `rx_enable` high, `base_load` has no effect.
- R9: During reset, `mem_req`, `s_ready` and `overrun_pulse` are low.
- R10: `s_ready` is low in every cycle that issues a descriptor read, and gaps in `s_valid` do not alter the memory write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Allows new frames to start |
| base_load | input | 1 | Loads the ring base (when disabled and idle) |
| base_value | input | 32 | Ring base byte address |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted |
| s_data | input | 8 | Frame byte |
| s_first | input | 1 | Beat is the first byte of a frame |
| s_last | input | 1 | Beat is the last byte of a frame |
| s_bcast | input | 1 | Frame has a broadcast destination (sampled on the first beat) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte strobes for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| overrun_pulse | output | 1 | Fetched descriptor was still owned |

## Verification
Some rules are checked by assertions on every cycle:
- the status write is always followed at once by an ownership write to the word 4 bytes below;
- an overrun pulse lasts one cycle and never coincides with a memory access;
- `s_ready` is low during descriptor reads;
- byte strobes are one-hot and match the address lane;
- a base load while enabled leaves the descriptor address unchanged;
- the ring index returns to 0 after a wrap.

The bench scenarios cover what needs a whole frame to show:
- how a frame's length is split over buffers, including exactly 128 and 129 bytes;
- a chain that wraps in the middle of a frame;
- ring-depth wrapping with no wrap bit set;
- overrun at the first buffer and in the middle of a frame;
- discarding of unmarked idle beats;
- status words and byte placement, checked against a behavioural model of the ring.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_FILL, ST_STATUS, ST_MARK, ST_DROP
  } rxr_state_e;

  localparam int OWN_POS   = 0;
  localparam int WRAP_POS  = 1;
  localparam int SOF_POS   = 14;
  localparam int EOF_POS   = 15;
  localparam int BCAST_POS = 31;
  localparam int LEN_W     = 12;
endpackage

// File: rtl/rxr_ring_ptr.sv
`timescale 1ns/1ps
module rxr_ring_ptr #(
  parameter int RING_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] base_in,
  input  logic        step,
  input  logic        wrap_mark,
  output logic [31:0] desc_addr
);
  localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

  logic [31:0]      base_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      idx_q  <= '0;
    end else if (step) begin
      idx_q <= (wrap_mark || idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  assign desc_addr = base_q + 32'({idx_q, 3'b000});

  // R6: the walk returns to the base after a wrap
  p_wrap_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (wrap_mark || idx_q == LAST_IDX)) |=> (idx_q == '0));

  // R8: a load restarts at index 0 from the new base
  p_load_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx_q == '0 && base_q == $past(base_in)));
endmodule

// File: rtl/rxr_fill_ctr.sv
`timescale 1ns/1ps
module rxr_fill_ctr #(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_clr,
  input  logic                         buf_clr,
  input  logic                         beat,
  output logic [$clog2(BUF_BYTES)-1:0] off,
  output logic                         last_slot,
  output logic [LEN_W-1:0]             frame_len
);
  localparam int OFF_W = $clog2(BUF_BYTES);

  logic [OFF_W-1:0] off_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      len_q <= '0;
    end else begin
      if (buf_clr)        off_q <= '0;
      else if (beat)      off_q <= off_q + 1'b1;
      if (frame_clr)      len_q <= '0;
      else if (beat)      len_q <= len_q + 1'b1;
    end
  end

  assign off       = off_q;
  assign last_slot = (off_q == OFF_W'(BUF_BYTES - 1));
  assign frame_len = len_q;

  // R3: a full buffer rolls the offset back to the start
  p_buf_roll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last_slot && !buf_clr) |=> (off_q == '0));
endmodule

// File: rtl/rxr_status_fmt.sv
`timescale 1ns/1ps
module rxr_status_fmt
  import rxr_pkg::*;
#(
  parameter int LW = 12
) (
  input  logic          is_first,
  input  logic          is_end,
  input  logic          bcast,
  input  logic [LW-1:0] len,
  output logic [31:0]   word
);
  always_comb begin
    word            = '0;
    word[SOF_POS]   = is_first;
    word[EOF_POS]   = is_end;
    word[BCAST_POS] = bcast && is_end;
    if (is_end) word[LW-1:0] = len;
  end
endmodule

// File: rtl/rxr_ring_writer.sv
`timescale 1ns/1ps
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int RING_DEPTH = 32,
  parameter int BUF_BYTES  = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_enable,
  input  logic        base_load,
  input  logic [31:0] base_value,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_first,
  input  logic        s_last,
  input  logic        s_bcast,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        overrun_pulse
);
  localparam int OFF_W = $clog2(BUF_BYTES);

  rxr_state_e       st_q, st_d;
  logic [29:0]      buf_base_q;
  logic             wrap_q, first_q, end_q, bcast_q;
  logic             frame_clr, buf_clr, beat, step, ptr_load, last_slot;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] frame_len;
  logic [31:0]      desc_addr, byte_addr, status_word;

  assign ptr_load  = base_load && !rx_enable && (st_q == ST_IDLE);
  assign byte_addr = {buf_base_q, 2'b00} + 32'(off);

  rxr_ring_ptr #(.RING_DEPTH(RING_DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .base_in(base_value),
    .step(step), .wrap_mark(wrap_q), .desc_addr(desc_addr)
  );

  rxr_fill_ctr #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .buf_clr(buf_clr),
    .beat(beat), .off(off), .last_slot(last_slot), .frame_len(frame_len)
  );

  rxr_status_fmt #(.LW(LEN_W)) u_fmt (
    .is_first(first_q), .is_end(end_q), .bcast(bcast_q),
    .len(frame_len), .word(status_word)
  );

  always_comb begin
    st_d          = st_q;
    s_ready       = 1'b0;
    mem_req       = 1'b0;
    mem_we        = 1'b0;
    mem_addr      = desc_addr;
    mem_be        = 4'hf;
    mem_wdata     = '0;
    overrun_pulse = 1'b0;
    frame_clr     = 1'b0;
    buf_clr       = 1'b0;
    beat          = 1'b0;
    step          = 1'b0;
    case (st_q)
      ST_IDLE: begin
        s_ready = rx_enable && !(s_valid && s_first);
        if (rx_enable && s_valid && s_first) begin
          st_d      = ST_FETCH;
          frame_clr = 1'b1;
        end
      end
      ST_FETCH: begin
        mem_req = 1'b1;
        st_d    = ST_CHECK;
      end
      ST_CHECK: begin
        if (mem_rdata[OWN_POS]) begin
          overrun_pulse = 1'b1;
          st_d          = ST_DROP;
        end else begin
          buf_clr = 1'b1;
          st_d    = ST_FILL;
        end
      end
      ST_FILL: begin
        s_ready = 1'b1;
        if (s_valid) begin
          beat      = 1'b1;
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = byte_addr;
          mem_be    = 4'b0001 << byte_addr[1:0];
          mem_wdata = {4{s_data}};
          if (s_last || last_slot) st_d = ST_STATUS;
        end
      end
      ST_STATUS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + 32'd4;
        mem_wdata = status_word;
        st_d      = ST_MARK;
      end
      ST_MARK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {buf_base_q, wrap_q, 1'b1};
        step      = 1'b1;
        st_d      = end_q ? ST_IDLE : ST_FETCH;
      end
      ST_DROP: begin
        s_ready = 1'b1;
        if (s_valid && s_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      buf_base_q <= '0;
      wrap_q     <= 1'b0;
      first_q    <= 1'b0;
      end_q      <= 1'b0;
      bcast_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && st_d == ST_FETCH) begin
        first_q <= 1'b1;
        bcast_q <= s_bcast;
      end
      if (st_q == ST_CHECK && !mem_rdata[OWN_POS]) begin
        buf_base_q <= mem_rdata[31:2];
        wrap_q     <= mem_rdata[WRAP_POS];
      end
      if (st_q == ST_FILL && s_valid) end_q <= s_last;
      if (st_q == ST_MARK) first_q <= 1'b0;
    end
  end

  // R5: status write is followed by the ownership write 4 bytes below
  p_status_then_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be == 4'hf && mem_addr[2]) |=>
    (mem_req && mem_we && mem_wdata[0] && mem_addr == $past(mem_addr) - 32'd4));

  // R7: overrun pulse is one cycle long and writes nothing
  p_ovr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_pulse |=> !overrun_pulse);
  p_ovr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_pulse |-> !mem_req);

  // R10: no beat is accepted while a descriptor is read
  p_read_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !s_ready);

  // R2: the read data cycle issues no access; byte strobes match the lane
  p_read_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req);
  p_byte_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be != 4'hf) |->
    ($onehot0(mem_be) && mem_be != 4'h0 && mem_be[mem_addr[1:0]]));

  // R8: a base load while enabled changes nothing
  p_load_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (base_load && rx_enable && st_q != ST_MARK) |=> $stable(desc_addr));
endmodule

// File: tb/sim_rxr_ring_writer.sv
`timescale 1ns/1ps
module sim_rxr_ring_writer;
  typedef struct packed {
    logic [1:0]  kind;   // 0 read, 1 write, 2 overrun
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_enable = 1'b0, base_load = 1'b0;
  logic [31:0] base_value = '0;
  logic        s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0, s_bcast = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready, mem_req, mem_we, overrun_pulse;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  always #4 clk = ~clk;

  rxr_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .base_load(base_load),
    .base_value(base_value), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_first(s_first), .s_last(s_last), .s_bcast(s_bcast),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .overrun_pulse(overrun_pulse)
  );

  // behavioural memory; software writes go through sw_* requests
  logic [31:0] mem [0:4095];
  logic [31:0] rdq;
  logic        sw_wr = 1'b0;
  logic [31:0] sw_a = '0, sw_d = '0;
  assign mem_rdata = rdq;

  always @(posedge clk) begin
    if (mem_req && !mem_we) rdq <= mem[mem_addr[13:2]];
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[13:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
    if (sw_wr) mem[sw_a[13:2]] = sw_d;
  end

  // reference model state
  ev_t         exq[$];
  logic [7:0]  pl [0:4095];
  bit          own_sh [0:31];
  bit          wrap_sh [0:31];
  logic [31:0] base_sh;
  int          idx_sh;
  string       scen = "R9";
  int          nchk = 0, nbad = 0, ev_chk = 0, ev_bad = 0, cyc = 0;

  function automatic logic [31:0] buf_of(input int i);
    return 32'h1000 + 32'(i * 128);
  endfunction

  function automatic string tag_of(input ev_t e);
    if (e.kind == 2'd0) return "R2";
    if (e.kind == 2'd2) return "R7";
    if (e.be != 4'hf)   return "R2";
    if (e.addr[2])      return "R4";
    return "R5";
  endfunction

  task automatic take_ev(input ev_t g);
    ev_t e;
    ev_chk++;
    if (exq.size() == 0) begin
      ev_bad++;
      $display("FAIL %s unexpected event actual kind=%0d addr=%h be=%h data=%h expected none",
               scen, g.kind, g.addr, g.be, g.data);
    end else begin
      e = exq.pop_front();
      if (g !== e) begin
        ev_bad++;
        $display("FAIL %s/%s actual kind=%0d addr=%h be=%h data=%h expected kind=%0d addr=%h be=%h data=%h",
                 tag_of(e), scen, g.kind, g.addr, g.be, g.data, e.kind, e.addr, e.be, e.data);
      end
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    ev_t got;
    if (rst_n) begin
      if (mem_req) begin
        got.kind = mem_we ? 2'd1 : 2'd0;
        got.addr = mem_addr;
        got.be   = mem_we ? mem_be : 4'h0;
        got.data = mem_we ? mem_wdata : 32'h0;
        take_ev(got);
      end
      if (overrun_pulse) begin
        got = '{2'd2, 32'h0, 4'h0, 32'h0};
        take_ev(got);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog actual cycles=%0d expected below 150000", cyc);
      $display("test done: total=%0d bad=%0d", nchk + ev_chk + 1, nbad + ev_bad + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic sw_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_wr = 1'b1; sw_a = a; sw_d = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic ring_init(input logic [31:0] base, input int wrap_at);
    base_sh = base;
    idx_sh  = 0;
    for (int i = 0; i < 32; i++) begin
      own_sh[i]  = 1'b0;
      wrap_sh[i] = (i == wrap_at);
      sw_write(base + 32'(i * 8), buf_of(i) | (wrap_sh[i] ? 32'h2 : 32'h0));
    end
  endtask

  task automatic release_all();
    for (int i = 0; i < 32; i++)
      if (own_sh[i]) begin
        own_sh[i] = 1'b0;
        sw_write(base_sh + 32'(i * 8), buf_of(i) | (wrap_sh[i] ? 32'h2 : 32'h0));
      end
  endtask

  task automatic hold_desc(input int i);
    own_sh[i] = 1'b1;
    sw_write(base_sh + 32'(i * 8), buf_of(i) | (wrap_sh[i] ? 32'h2 : 32'h0) | 32'h1);
  endtask

  function automatic int next_idx(input int i);
    return (wrap_sh[i] || i == 31) ? 0 : i + 1;
  endfunction

  task automatic predict(input int len, input bit bc);
    int pos;
    bit first;
    pos = 0;
    first = 1'b1;
    while (pos < len) begin
      int n;
      bit fin;
      logic [31:0] da, a;
      da = base_sh + 32'(idx_sh * 8);
      exq.push_back('{2'd0, da, 4'h0, 32'h0});
      if (own_sh[idx_sh]) begin
        exq.push_back('{2'd2, 32'h0, 4'h0, 32'h0});
        break;
      end
      n   = (len - pos > 128) ? 128 : len - pos;
      fin = (pos + n == len);
      for (int k = 0; k < n; k++) begin
        a = buf_of(idx_sh) + 32'(k);
        exq.push_back('{2'd1, a, 4'b0001 << a[1:0], {4{pl[pos + k]}}});
      end
      exq.push_back('{2'd1, da + 32'd4, 4'hf,
                      {bc && fin, 15'b0, fin, first, 2'b0, fin ? 12'(len) : 12'h0}});
      exq.push_back('{2'd1, da, 4'hf, buf_of(idx_sh) | (wrap_sh[idx_sh] ? 32'h2 : 32'h0) | 32'h1});
      own_sh[idx_sh] = 1'b1;
      idx_sh = next_idx(idx_sh);
      pos   += n;
      first  = 1'b0;
    end
  endtask

  task automatic drive_byte(input logic [7:0] d, input bit f, input bit l, input bit bc,
                            output int waits);
    bit acc;
    s_valid = 1'b1; s_data = d; s_first = f; s_last = l; s_bcast = bc;
    acc = 1'b0;
    waits = 0;
    while (!acc) begin
      #1 acc = s_ready;
      if (!acc) waits++;
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input int len, input bit bc, input bit gaps, input int seed);
    int w;
    for (int k = 0; k < len; k++) pl[k] = 8'(k * 7 + seed);
    predict(len, bc);
    @(negedge clk);
    for (int k = 0; k < len; k++) begin
      if (gaps && (k % 5 == 3)) @(negedge clk);
      drive_byte(pl[k], k == 0, k == len - 1, bc, w);
    end
    wait_idle();
  endtask

  initial begin
    int w;
    // R9: reset state
    repeat (2) @(negedge clk);
    chk(mem_req == 1'b0, "R9", "mem_req in reset", int'(mem_req), 0);
    chk(s_ready == 1'b0, "R9", "s_ready in reset", int'(s_ready), 0);
    chk(overrun_pulse == 1'b0, "R9", "overrun in reset", int'(overrun_pulse), 0);
    ring_init(32'h100, 5);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    base_value = 32'h100; base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;

    // R1: disabled idle never starts a frame
    scen = "R1";
    s_valid = 1'b1; s_first = 1'b1; s_data = 8'h5a;
    for (int i = 0; i < 4; i++) begin
      #1 chk(s_ready == 1'b0, "R1", "ready while disabled", int'(s_ready), 0);
      @(negedge clk);
    end
    s_valid = 1'b0; s_first = 1'b0;
    rx_enable = 1'b1;
    @(negedge clk);
    // R1: unmarked idle beats are discarded without stall
    for (int i = 0; i < 3; i++) begin
      drive_byte(8'(i), 1'b0, 1'b0, 1'b0, w);
      chk(w == 0, "R1", "idle junk beat stall cycles", w, 0);
    end
    repeat (3) @(negedge clk);

    // R2/R4/R5: short and single-buffer frames
    scen = "R4"; send_frame(1, 1'b1, 1'b0, 3);   release_all();
    scen = "R2"; send_frame(60, 1'b0, 1'b0, 9);  release_all();
    scen = "R3"; send_frame(128, 1'b1, 1'b0, 1); release_all();
    scen = "R3"; send_frame(129, 1'b0, 1'b0, 4); release_all();
    // R6: chain wraps mid-frame at the wrap-bit descriptor
    scen = "R6"; send_frame(300, 1'b1, 1'b0, 2); release_all();
    chk(idx_sh == 2, "R6", "model index after wrap", idx_sh, 2);
    // R10: gaps in valid
    scen = "R10"; send_frame(150, 1'b0, 1'b1, 6); release_all();

    // R7: overrun on the first buffer, then recovery on the same descriptor
    scen = "R7";
    hold_desc(idx_sh);
    send_frame(40, 1'b0, 1'b0, 8);
    release_all();
    send_frame(40, 1'b1, 1'b0, 11); release_all();
    // R7: overrun in the middle of a frame
    hold_desc(next_idx(idx_sh));
    send_frame(200, 1'b0, 1'b1, 5);
    release_all();
    send_frame(20, 1'b0, 1'b0, 12); release_all();

    // R8: load while enabled is ignored
    scen = "R8";
    @(negedge clk);
    base_value = 32'h800; base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;
    send_frame(30, 1'b0, 1'b0, 13); release_all();

    // R8/R6: reload while disabled, ring without wrap bits wraps at depth
    rx_enable = 1'b0;
    ring_init(32'h400, -1);
    @(negedge clk);
    base_value = 32'h400; base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;
    rx_enable = 1'b1;
    scen = "R6";
    for (int f = 0; f < 17; f++) begin
      send_frame(200, f[0], 1'b0, f);
      release_all();
    end
    chk(idx_sh == 2, "R6", "model index after depth wrap", idx_sh, 2);

    repeat (5) @(negedge clk);
    chk(exq.size() == 0, "R2", "pending expected events", exq.size(), 0);
    $display("test done: total=%0d bad=%0d", nchk + ev_chk, nbad + ev_bad);
    $finish;
  end
endmodule